// File: doc/BRIEF.md
# Address/Arithmetic Unit Synchronization Flags

This block keeps the shared control state that lets an address-generating unit and an arithmetic unit run on their own, joined only by address FIFOs and data queues, and still meet at well-defined points. It holds a run bit for each unit, a wait-interlock bit that parks the address unit at a barrier, and a small bank of shared system flags that either unit may set or clear.

From this state and the emptiness of the read-address FIFO and the input data queue, the block derives two completion conditions. The arithmetic unit tests them to end its loops. One condition means the input stream is fully consumed because the address unit has halted. The other means the same thing for a batch that ends at a barrier. When the arithmetic unit drops the interlock, the block raises a one-cycle release pulse. In that cycle the address unit's issue enable also returns, so both units issue their next instruction together. The arithmetic unit can leave a decision in a system flag before it releases the barrier, and the address unit branches on that flag once it runs again.

Top module: `unit_sync_flags`

## Requirements
- R1: While rst_ni is low, the run bits, the interlock bit, the release pulse and all system flags are 0.
- R2: addr_run_o becomes 1 one cycle after ext_start_i. It becomes 0 one cycle after addr_halt_i is asserted in a cycle where addr_go_o is 1. If both are asserted in the same cycle, the halt wins.
- R3: arith_run_o becomes 1 one cycle after addr_arith_start_i is asserted in a cycle where addr_go_o is 1. It becomes 0 one cycle after arith_halt_i. If both are asserted in the same cycle, the halt wins.
- R4: wait_lock_o becomes 1 one cycle after addr_wait_set_i is asserted in a cycle where addr_go_o is 1. It becomes 0 one cycle after arith_wait_clr_i is asserted in a cycle where arith_run_o is 1. If both are asserted in the same cycle, the clear wins.
- R5: addr_go_o is 1 exactly when addr_run_o is 1 and wait_lock_o is 0.
- R6: release_o is high for exactly the one cycle in which wait_lock_o first reads 0 after having been 1.
- R7: Each system flag bit k is set by flag_set_i[k] and cleared by flag_clr_i[k], taking effect on the next cycle. Clear wins when both are asserted together. The other bits are not affected.
- R8: in_fin_o equals (not addr_run_o) and raf_empty_i and iq_empty_i in the same cycle.
- R9: wait_fin_o equals wait_lock_o and raf_empty_i and iq_empty_i in the same cycle.
- R10: addr_halt_i, addr_arith_start_i and addr_wait_set_i have no effect in a cycle where addr_go_o is 0. arith_wait_clr_i has no effect in a cycle where arith_run_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_start_i | input | 1 | External start of the address unit |
| addr_halt_i | input | 1 | Address unit halts itself |
| addr_arith_start_i | input | 1 | Address unit starts the arithmetic unit |
| addr_wait_set_i | input | 1 | Address unit enters the barrier |
| arith_halt_i | input | 1 | Arithmetic unit halts itself |
| arith_wait_clr_i | input | 1 | Arithmetic unit releases the barrier |
| flag_set_i | input | NUM_FLAGS | Per-bit set strobes for the system flags |
| flag_clr_i | input | NUM_FLAGS | Per-bit clear strobes for the system flags |
| raf_empty_i | input | 1 | Read-address FIFO is empty |
| iq_empty_i | input | 1 | Input data queue is empty |
| addr_run_o | output | 1 | Address unit run bit |
| arith_run_o | output | 1 | Arithmetic unit run bit |
| wait_lock_o | output | 1 | Wait-interlock bit |
| addr_go_o | output | 1 | Address unit may issue this cycle |
| release_o | output | 1 | Barrier release pulse |
| sys_flag_o | output | NUM_FLAGS | Shared system flags |
| in_fin_o | output | 1 | Input finished, with the address unit halted |
| wait_fin_o | output | 1 | Input finished, with the address unit at the barrier |

## Verification
The assertions check on every cycle that the run bits, the interlock bit and the flags follow their strobes one cycle later with clear priority. They also check that strobes gated by a stalled unit leave the state alone, and that the release pulse is a single cycle that follows a clearing of the interlock. The bench scenarios cover the rest. A full barrier round trip shows a flag decision surviving the release, with the address unit and the release pulse resuming together. Random stimulus compares both completion conditions against every mix of run state, interlock state and FIFO emptiness.

// File: rtl/usf_pkg.sv
package usf_pkg;
  localparam int unsigned DEF_NUM_FLAGS = 4;

  typedef struct packed {
    logic addr_run;
    logic arith_run;
    logic wait_lock;
  } unit_state_t;
endpackage

// File: rtl/usf_run_ctrl.sv
module usf_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_start_i,
  input  logic addr_halt_i,
  input  logic addr_arith_start_i,
  input  logic arith_halt_i,
  input  logic wait_lock_i,
  output logic addr_run_o,
  output logic arith_run_o,
  output logic addr_go_o
);
  logic addr_run_q, arith_run_q;
  logic addr_go;
  logic addr_run_d, arith_run_d;

  assign addr_go = addr_run_q & ~wait_lock_i;

  // clear has priority over set on both run bits
  always_comb begin
    addr_run_d  = (addr_run_q | ext_start_i) & ~(addr_halt_i & addr_go);
    arith_run_d = (arith_run_q | (addr_arith_start_i & addr_go)) & ~arith_halt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_run_q  <= 1'b0;
      arith_run_q <= 1'b0;
    end else begin
      addr_run_q  <= addr_run_d;
      arith_run_q <= arith_run_d;
    end
  end

  assign addr_run_o  = addr_run_q;
  assign arith_run_o = arith_run_q;
  assign addr_go_o   = addr_go;

  assert_addr_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_start_i && !(addr_halt_i && addr_go_o)) |=> addr_run_o);
  assert_addr_halt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_halt_i && addr_go_o) |=> !addr_run_o);
  assert_arith_halt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arith_halt_i |=> !arith_run_o);
  assert_stalled_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_go_o && !arith_halt_i) |=> $stable(arith_run_o));
  assert_stalled_halt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_go_o && addr_run_o) |=> addr_run_o);
endmodule

// File: rtl/usf_interlock.sv
module usf_interlock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_set_i,
  input  logic wait_clr_i,
  input  logic addr_go_i,
  input  logic arith_run_i,
  output logic wait_lock_o,
  output logic release_o
);
  logic wait_q, wait_d;
  logic rel_q;

  always_comb begin
    wait_d = (wait_q | (wait_set_i & addr_go_i)) & ~(wait_clr_i & arith_run_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      rel_q  <= wait_q & ~wait_d;
    end
  end

  assign wait_lock_o = wait_q;
  assign release_o   = rel_q;

  assert_wait_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_set_i && addr_go_i && !(wait_clr_i && arith_run_i)) |=> wait_lock_o);
  assert_wait_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_clr_i && arith_run_i) |=> !wait_lock_o);
  assert_clr_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_lock_o && !arith_run_i) |=> wait_lock_o);
  assert_release_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> (!wait_lock_o && $past(wait_lock_o)));
  assert_release_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !release_o);
endmodule

// File: rtl/usf_flag_bank.sv
module usf_flag_bank #(
  parameter int unsigned NUM_FLAGS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flag_o
);
  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (clr_i[k]) q <= 1'b0;
      else if (set_i[k]) q <= 1'b1;
    end
    assign flag_o[k] = q;

    assert_flag_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] |=> !flag_o[k]);
    assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[k] && !clr_i[k]) |=> flag_o[k]);
    assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[k] && !clr_i[k]) |=> $stable(flag_o[k]));
  end
endmodule

// File: rtl/usf_done_detect.sv
module usf_done_detect (
  input  logic addr_run_i,
  input  logic wait_lock_i,
  input  logic raf_empty_i,
  input  logic iq_empty_i,
  output logic in_fin_o,
  output logic wait_fin_o
);
  logic drained;
  assign drained    = raf_empty_i & iq_empty_i;
  assign in_fin_o   = ~addr_run_i & drained;
  assign wait_fin_o = wait_lock_i & drained;
endmodule

// File: rtl/unit_sync_flags.sv
module unit_sync_flags #(
  parameter int unsigned NUM_FLAGS = usf_pkg::DEF_NUM_FLAGS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ext_start_i,
  input  logic                 addr_halt_i,
  input  logic                 addr_arith_start_i,
  input  logic                 addr_wait_set_i,
  input  logic                 arith_halt_i,
  input  logic                 arith_wait_clr_i,
  input  logic [NUM_FLAGS-1:0] flag_set_i,
  input  logic [NUM_FLAGS-1:0] flag_clr_i,
  input  logic                 raf_empty_i,
  input  logic                 iq_empty_i,
  output logic                 addr_run_o,
  output logic                 arith_run_o,
  output logic                 wait_lock_o,
  output logic                 addr_go_o,
  output logic                 release_o,
  output logic [NUM_FLAGS-1:0] sys_flag_o,
  output logic                 in_fin_o,
  output logic                 wait_fin_o
);
  usf_pkg::unit_state_t st;
  logic addr_go;
  logic release_w;

  usf_run_ctrl u_run (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .ext_start_i        (ext_start_i),
    .addr_halt_i        (addr_halt_i),
    .addr_arith_start_i (addr_arith_start_i),
    .arith_halt_i       (arith_halt_i),
    .wait_lock_i        (st.wait_lock),
    .addr_run_o         (st.addr_run),
    .arith_run_o        (st.arith_run),
    .addr_go_o          (addr_go)
  );

  usf_interlock u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wait_set_i  (addr_wait_set_i),
    .wait_clr_i  (arith_wait_clr_i),
    .addr_go_i   (addr_go),
    .arith_run_i (st.arith_run),
    .wait_lock_o (st.wait_lock),
    .release_o   (release_w)
  );

  usf_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set_i),
    .clr_i  (flag_clr_i),
    .flag_o (sys_flag_o)
  );

  usf_done_detect u_done (
    .addr_run_i  (st.addr_run),
    .wait_lock_i (st.wait_lock),
    .raf_empty_i (raf_empty_i),
    .iq_empty_i  (iq_empty_i),
    .in_fin_o    (in_fin_o),
    .wait_fin_o  (wait_fin_o)
  );

  assign addr_run_o  = st.addr_run;
  assign arith_run_o = st.arith_run;
  assign wait_lock_o = st.wait_lock;
  assign addr_go_o   = addr_go;
  assign release_o   = release_w;

  assert_go_on_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o && addr_run_o) |-> addr_go_o);
  assert_no_infin_running_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_run_o |-> !in_fin_o);
  assert_no_waitfin_unlocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_lock_o |-> !wait_fin_o);
endmodule

// File: tb/unit_sync_flags_test.sv
module unit_sync_flags_test;
  localparam int NF = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_start_i = 0, addr_halt_i = 0, addr_arith_start_i = 0, addr_wait_set_i = 0;
  logic arith_halt_i = 0, arith_wait_clr_i = 0;
  logic [NF-1:0] flag_set_i = '0, flag_clr_i = '0;
  logic raf_empty_i = 1, iq_empty_i = 1;
  logic addr_run_o, arith_run_o, wait_lock_o, addr_go_o, release_o, in_fin_o, wait_fin_o;
  logic [NF-1:0] sys_flag_o;

  // bench model state
  logic m_ar = 0, m_r = 0, m_w = 0, m_rel = 0;
  logic [NF-1:0] m_f = '0;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  unit_sync_flags #(.NUM_FLAGS(NF)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_start_i(ext_start_i), .addr_halt_i(addr_halt_i),
    .addr_arith_start_i(addr_arith_start_i), .addr_wait_set_i(addr_wait_set_i),
    .arith_halt_i(arith_halt_i), .arith_wait_clr_i(arith_wait_clr_i),
    .flag_set_i(flag_set_i), .flag_clr_i(flag_clr_i), .raf_empty_i(raf_empty_i),
    .iq_empty_i(iq_empty_i), .addr_run_o(addr_run_o), .arith_run_o(arith_run_o),
    .wait_lock_o(wait_lock_o), .addr_go_o(addr_go_o), .release_o(release_o),
    .sys_flag_o(sys_flag_o), .in_fin_o(in_fin_o), .wait_fin_o(wait_fin_o)
  );

  task automatic chk(input string req, input string what, input logic [NF-1:0] act, input logic [NF-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic exp_go();
    return m_ar & ~m_w;
  endfunction

  task automatic check_all();
    chk("R2", "addr_run", NF'(addr_run_o), NF'(m_ar));
    chk("R3", "arith_run", NF'(arith_run_o), NF'(m_r));
    chk("R4", "wait_lock", NF'(wait_lock_o), NF'(m_w));
    chk("R5", "addr_go", NF'(addr_go_o), NF'(exp_go()));
    chk("R6", "release", NF'(release_o), NF'(m_rel));
    chk("R7", "flags", sys_flag_o, m_f);
    chk("R8", "in_fin", NF'(in_fin_o), NF'(~m_ar & raf_empty_i & iq_empty_i));
    chk("R9", "wait_fin", NF'(wait_fin_o), NF'(m_w & raf_empty_i & iq_empty_i));
  endtask

  // inputs already driven at a negedge; check, advance one clock, land on next negedge
  task automatic tick();
    logic go, nar, nr, nw;
    logic [NF-1:0] nf;
    #1;
    check_all();
    go  = exp_go();
    nar = (m_ar | ext_start_i) & ~(addr_halt_i & go);
    nr  = (m_r | (addr_arith_start_i & go)) & ~arith_halt_i;
    nw  = (m_w | (addr_wait_set_i & go)) & ~(arith_wait_clr_i & m_r);
    nf  = (m_f | flag_set_i) & ~flag_clr_i;
    @(posedge clk_i);
    m_rel = m_w & ~nw;
    m_ar = nar; m_r = nr; m_w = nw; m_f = nf;
    @(negedge clk_i);
  endtask

  task automatic idle();
    ext_start_i = 0; addr_halt_i = 0; addr_arith_start_i = 0; addr_wait_set_i = 0;
    arith_halt_i = 0; arith_wait_clr_i = 0; flag_set_i = '0; flag_clr_i = '0;
  endtask

  initial begin
    #3_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1", "run/lock/rel", {1'b0, addr_run_o, arith_run_o, wait_lock_o | release_o}, '0);
    chk("R1", "flags", sys_flag_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10: strobes from a halted address unit are ignored
    addr_arith_start_i = 1; addr_wait_set_i = 1; tick(); idle();
    chk("R10", "arith_run after stalled start", NF'(arith_run_o), '0);
    chk("R10", "wait after stalled set", NF'(wait_lock_o), '0);

    // barrier round trip
    ext_start_i = 1; tick(); idle();
    addr_arith_start_i = 1; tick(); idle();
    chk("R3", "arith started", NF'(arith_run_o), 1);
    addr_wait_set_i = 1; raf_empty_i = 1; iq_empty_i = 1; tick(); idle();
    chk("R9", "wait_fin at barrier", NF'(wait_fin_o), 1);
    chk("R5", "addr stalled", NF'(addr_go_o), 0);
    // R10: stalled address unit cannot halt itself
    addr_halt_i = 1; tick(); idle();
    chk("R10", "addr_run kept while stalled", NF'(addr_run_o), 1);
    flag_set_i = 4'b0100; tick(); idle();
    arith_wait_clr_i = 1; tick(); idle();
    chk("R6", "release with go", NF'({release_o, addr_go_o}), 2'b11);
    chk("R7", "decision flag kept", sys_flag_o, 4'b0100);
    tick();
    chk("R6", "release single cycle", NF'(release_o), 0);

    // clear-wins collisions
    flag_set_i = 4'b1111; flag_clr_i = 4'b0101; tick(); idle();
    chk("R7", "clear wins per bit", sys_flag_o, 4'b1010);
    addr_arith_start_i = 1; arith_halt_i = 1; tick(); idle();
    chk("R3", "halt wins", NF'(arith_run_o), 0);
    ext_start_i = 1; addr_halt_i = 1; tick(); idle();
    chk("R2", "halt wins", NF'(addr_run_o), 0);
    // R10: clear from halted arithmetic unit ignored
    ext_start_i = 1; tick(); idle();
    addr_wait_set_i = 1; tick(); idle();
    arith_wait_clr_i = 1; tick(); idle();
    chk("R10", "wait kept, arith halted", NF'(wait_lock_o), 1);
    raf_empty_i = 1; iq_empty_i = 0; tick();
    chk("R9", "queue not empty", NF'(wait_fin_o), 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      ext_start_i        = ($urandom_range(7) == 0);
      addr_halt_i        = ($urandom_range(15) == 0);
      addr_arith_start_i = ($urandom_range(5) == 0);
      addr_wait_set_i    = ($urandom_range(7) == 0);
      arith_halt_i       = ($urandom_range(15) == 0);
      arith_wait_clr_i   = ($urandom_range(3) == 0);
      flag_set_i         = NF'($urandom) & NF'($urandom);
      flag_clr_i         = NF'($urandom) & NF'($urandom);
      raf_empty_i        = $urandom_range(1);
      iq_empty_i         = $urandom_range(1);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule